// File: doc/BRIEF.md
# Condition Register Logic Unit

This block holds a 32-bit condition register divided into eight 4-bit fields and carries out the condition-register instructions of a processor core in one cycle each. An operation arrives with a valid strobe, a 4-bit opcode, a 32-bit data operand and three 5-bit selectors: two sources (A and B) and one destination (D). The operations are:

- load the whole register from the data operand;
- copy one field onto another;
- move the exception-status bits of an integer exception register into a field;
- combine two single register bits with one of eight boolean functions and write the result into a third bit.

The register is always visible on a read port.

The integer exception register is modelled inside the block. It is 32 bits wide and has its own write port and a continuous read port. Its status bits are the top three: summary overflow at bit 31, overflow at bit 30 and carry at bit 29, counting from the LSB. The status-move operation clears these three bits after copying them.

All selector numbering is big-endian. Bit index 0 is the MSB of the register and field 0 is its top nibble.

Top module: `cr_logic_unit`

## Requirements
- R1: A synchronous active-high reset makes `crOut` and `xerOut` both zero on the cycle after it is sampled.
- R2: Opcode 0x0 (register load) makes `crOut` equal to `opData` exactly on the cycle after the strobe.
- R3: Selectors are big-endian. Bit index i addresses `crOut[31-i]`, and field index f addresses `crOut[31-4f -: 4]`.
- R4: Opcode 0x1 (field copy) writes field `selA[2:0]` into field `selD[2:0]`. `selA[4:3]` and `selD[4:3]` are ignored.
- R5: Opcodes 0x8 to 0xF compute D = f(A, B) on single bits, where A, B and D are the bits picked by `selA`, `selB` and `selD`. The functions are: 0x8 AND, 0x9 A AND NOT B, 0xA OR, 0xB A OR NOT B, 0xC XOR, 0xD NAND, 0xE NOR, 0xF XNOR.
- R6: A boolean bit operation changes only the destination bit, and a field copy changes only the destination field.
- R7: When a source selector equals the destination selector, the operation uses the bit value from before the operation.
- R8: Opcode 0x2 (status move) writes {xer[31], xer[30], xer[29], 0} into field `selD[2:0]` and leaves the other seven fields unchanged.
- R9: The status move clears `xer[31:29]` and keeps `xer[28:0]`. If `xerWrEn` is high in the same cycle, the written value wins in the exception register, and the condition register still receives the old status bits.
- R10: With `opValid` low, or with the unused opcodes 0x3 to 0x7, the condition register is unchanged.
- R11: `xerWrEn` loads `xerWrData` into the exception register, and the value appears on `xerOut` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | Operation strobe |
| opCode | input | 4 | Operation code |
| opData | input | 32 | Data operand for register load |
| selA | input | 5 | Source A bit or field selector |
| selB | input | 5 | Source B bit selector |
| selD | input | 5 | Destination bit or field selector |
| xerWrEn | input | 1 | Exception-register write enable |
| xerWrData | input | 32 | Exception-register write data |
| crOut | output | 32 | Condition register contents |
| xerOut | output | 32 | Exception register contents |

## Verification
The bench targets four kinds of error.

- **Bit and field numbering.** Every boolean function is swept over every destination bit and over all 32 values of source A, with source B tied to each A. A unit that numbered bits from the LSB, or that mixed up the complemented operand of the AND-NOT and OR-NOT functions, would set the mirror bit or produce the wrong truth value. The sweep includes cases where the sources equal the destination; a unit that used an already-updated bit there would diverge from the running model.
- **Field copy.** All 64 source and destination pairs are checked. A copy that wrote more than one nibble, or that decoded the upper selector bits, would show up.
- **Status move.** Every field is combined with every status pattern, with low exception bits left set. This exposes a move that failed to clear the status bits, cleared the wrong ones, or wrote a nonzero LSB into the field.
- **Write collision.** A status move is issued in the same cycle as an exception-register write, to check which of the two wins.

// File: rtl/cr_pkg.sv
package cr_pkg;

  localparam logic [3:0] OP_LOAD = 4'h0;
  localparam logic [3:0] OP_FCOPY = 4'h1;
  localparam logic [3:0] OP_XMOVE = 4'h2;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic       wrAll;
    logic       copyField;
    logic       xerMove;
    logic       bitOp;
    logic [2:0] fn;
  } crStrobe_t;

  function automatic logic crBitFn(input logic [2:0] fn, input logic a, input logic b);
    case (fn)
      3'd0: crBitFn = a & b;
      3'd1: crBitFn = a & ~b;
      3'd2: crBitFn = a | b;
      3'd3: crBitFn = a | ~b;
      3'd4: crBitFn = a ^ b;
      3'd5: crBitFn = ~(a & b);
      3'd6: crBitFn = ~(a | b);
      default: crBitFn = ~(a ^ b);
    endcase
  endfunction

endpackage

// File: rtl/cr_ctrl.sv
module cr_ctrl
  import cr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       opValid,
  input  logic [3:0] opCode,
  output crStrobe_t  stb
);

  always_comb begin
    stb           = '0;
    stb.fn        = opCode[2:0];
    if (opValid) begin
      stb.bitOp     = opCode[3];
      stb.wrAll     = (opCode == OP_LOAD);
      stb.copyField = (opCode == OP_FCOPY);
      stb.xerMove   = (opCode == OP_XMOVE);
    end
  end

  // R10: at most one datapath action per cycle, none without a strobe
  p_single_action_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.wrAll, stb.copyField, stb.xerMove, stb.bitOp}));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !opValid |-> !(stb.wrAll | stb.copyField | stb.xerMove | stb.bitOp));

endmodule

// File: rtl/cr_datapath.sv
module cr_datapath
  import cr_pkg::*;
#(
  parameter int CR_W    = 32,
  parameter int FIELD_W = 4,
  parameter int XER_W   = 32,
  parameter int STAT_N  = 3,
  parameter int SEL_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  crStrobe_t        stb,
  input  logic [CR_W-1:0]  opData,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selB,
  input  logic [SEL_W-1:0] selD,
  input  logic             xerWrEn,
  input  logic [XER_W-1:0] xerWrData,
  output logic [CR_W-1:0]  crQ,
  output logic [XER_W-1:0] xerQ
);

  localparam int NUM_FIELDS = CR_W / FIELD_W;
  localparam int FSEL_W     = $clog2(NUM_FIELDS);
  localparam logic [CR_W-1:0] MSB_ONE = {1'b1, {(CR_W-1){1'b0}}};

  logic [FSEL_W-1:0]  srcIdx, dstIdx;
  logic [FIELD_W-1:0] srcField, newField;
  logic [CR_W-1:0]    fieldMerged, bitMerged, crNext, maskA, maskB, maskD, fieldMask;
  logic [XER_W-1:0]   xerNext;
  logic               bitA, bitB, bitRes;

  assign srcIdx = selA[FSEL_W-1:0];
  assign dstIdx = selD[FSEL_W-1:0];

  // Big-endian bit masks: index 0 is the MSB
  assign maskA = MSB_ONE >> selA;
  assign maskB = MSB_ONE >> selB;
  assign maskD = MSB_ONE >> selD;

  assign bitA   = |(crQ & maskA);
  assign bitB   = |(crQ & maskB);
  assign bitRes = crBitFn(stb.fn, bitA, bitB);
  assign bitMerged = bitRes ? (crQ | maskD) : (crQ & ~maskD);

  always_comb begin
    srcField = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (srcIdx == FSEL_W'(i))
        srcField = crQ[(NUM_FIELDS-1-i)*FIELD_W +: FIELD_W];
    end
  end

  assign newField = stb.xerMove ? {xerQ[XER_W-1 -: STAT_N], {(FIELD_W-STAT_N){1'b0}}}
                                : srcField;

  // One replacement lane per field, field 0 at the top nibble
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    localparam int LO = (NUM_FIELDS-1-g)*FIELD_W;
    assign fieldMerged[LO +: FIELD_W] = (dstIdx == FSEL_W'(g)) ? newField
                                                              : crQ[LO +: FIELD_W];
    assign fieldMask[LO +: FIELD_W]   = {FIELD_W{dstIdx == FSEL_W'(g)}};
  end

  always_comb begin
    crNext = crQ;
    if (stb.wrAll)                        crNext = opData;
    else if (stb.copyField | stb.xerMove) crNext = fieldMerged;
    else if (stb.bitOp)                   crNext = bitMerged;
  end

  always_comb begin
    xerNext = xerQ;
    if (xerWrEn)          xerNext = xerWrData;
    else if (stb.xerMove) xerNext = {{STAT_N{1'b0}}, xerQ[XER_W-STAT_N-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crQ  <= '0;
      xerQ <= '0;
    end else begin
      crQ  <= crNext;
      xerQ <= xerNext;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (crQ == '0 && xerQ == '0));

  p_load_exact_r2: assert property (@(posedge clk) disable iff (rst)
    stb.wrAll |=> crQ == $past(opData));

  p_bitop_one_bit_r6: assert property (@(posedge clk) disable iff (rst)
    stb.bitOp |=> ((crQ ^ $past(crQ)) & ~$past(maskD)) == '0);

  p_copy_one_field_r6: assert property (@(posedge clk) disable iff (rst)
    (stb.copyField | stb.xerMove) |=> ((crQ ^ $past(crQ)) & ~$past(fieldMask)) == '0);

  p_status_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    (stb.xerMove && !xerWrEn) |=> xerQ[XER_W-1 -: STAT_N] == '0);

  p_xer_write_r11: assert property (@(posedge clk) disable iff (rst)
    xerWrEn |=> xerQ == $past(xerWrData));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(stb.wrAll | stb.copyField | stb.xerMove | stb.bitOp) |=> $stable(crQ));

endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit
  import cr_pkg::*;
#(
  parameter int CR_W    = 32,
  parameter int FIELD_W = 4,
  parameter int XER_W   = 32,
  parameter int SEL_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic [3:0]       opCode,
  input  logic [CR_W-1:0]  opData,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selB,
  input  logic [SEL_W-1:0] selD,
  input  logic             xerWrEn,
  input  logic [XER_W-1:0] xerWrData,
  output logic [CR_W-1:0]  crOut,
  output logic [XER_W-1:0] xerOut
);

  crStrobe_t stb;

  cr_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .opValid (opValid),
    .opCode  (opCode),
    .stb     (stb)
  );

  cr_datapath #(
    .CR_W    (CR_W),
    .FIELD_W (FIELD_W),
    .XER_W   (XER_W),
    .STAT_N  (3),
    .SEL_W   (SEL_W)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .opData    (opData),
    .selA      (selA),
    .selB      (selB),
    .selD      (selD),
    .xerWrEn   (xerWrEn),
    .xerWrData (xerWrData),
    .crQ       (crOut),
    .xerQ      (xerOut)
  );

endmodule

// File: tb/tb_cr_logic_unit.sv
module tb_cr_logic_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [3:0]  opCode;
  logic [31:0] opData;
  logic [4:0]  selA, selB, selD;
  logic        xerWrEn;
  logic [31:0] xerWrData;
  logic [31:0] crOut, xerOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] crM, xerM;

  always #4 clk = ~clk;

  cr_logic_unit dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode), .opData(opData),
    .selA(selA), .selB(selB), .selD(selD), .xerWrEn(xerWrEn),
    .xerWrData(xerWrData), .crOut(crOut), .xerOut(xerOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic refFn(input int op, input logic a, input logic b);
    case (op)
      8: return a && b;
      9: return a && !b;
      10: return a || b;
      11: return a || !b;
      12: return a != b;
      13: return !(a && b);
      14: return !(a || b);
      default: return a == b;
    endcase
  endfunction

  // Drive one operation at a falling edge; it is sampled at the next rising edge
  task automatic issue(input logic [3:0] op, input logic [31:0] d,
                       input int a, input int b, input int dd,
                       input logic xw, input logic [31:0] xd);
    @(negedge clk);
    opValid = 1'b1; opCode = op; opData = d;
    selA = 5'(a); selB = 5'(b); selD = 5'(dd);
    xerWrEn = xw; xerWrData = xd;
    @(negedge clk);
    opValid = 1'b0; xerWrEn = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; opValid = 1'b0; opCode = '0; opData = '0;
    selA = '0; selB = '0; selD = '0; xerWrEn = 1'b0; xerWrData = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 cr reset", crOut, 32'h0);
    chk("R1 xer reset", xerOut, 32'h0);

    // R2: load patterns
    issue(4'h0, 32'haaaaaaaa, 0, 0, 0, 1'b0, 0);
    chk("R2 load", crOut, 32'haaaaaaaa);
    issue(4'h0, 32'h55555555, 0, 0, 0, 1'b0, 0);
    chk("R2 load", crOut, 32'h55555555);

    // R4 R3 known copies
    issue(4'h0, 32'h01234567, 0, 0, 0, 1'b0, 0);
    issue(4'h1, 0, 0, 0, 4, 1'b0, 0);
    chk("R4 copy f0->f4", crOut, 32'h01230567);
    issue(4'h0, 32'h01234567, 0, 0, 0, 1'b0, 0);
    issue(4'h1, 0, 7, 0, 0, 1'b0, 0);
    chk("R4 copy f7->f0", crOut, 32'h71234567);

    // R3 R5 known bit cases
    issue(4'h0, 32'h0000ffff, 0, 0, 0, 1'b0, 0);
    issue(4'h8, 0, 16, 17, 0, 1'b0, 0);
    chk("R3 R5 and 16,17->0", crOut, 32'h8000ffff);
    issue(4'h0, 32'h0000ffff, 0, 0, 0, 1'b0, 0);
    issue(4'h8, 0, 0, 16, 0, 1'b0, 0);
    chk("R7 and 0,16->0", crOut, 32'h0000ffff);

    // R4 R6: all field pairs, upper selector bits set to show they are ignored
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 8; d++) begin
        crM = 32'h89abcdef ^ (32'h11111111 * s);
        issue(4'h0, crM, 0, 0, 0, 1'b0, 0);
        issue(4'h1, 0, s + 8 * ((s + d) % 4), 0, d + 8 * (d % 4), 1'b0, 0);
        crM[31-4*d -: 4] = crM[31-4*s -: 4];
        chk("R4 R6 field copy", crOut, crM);
      end
    end

    // R5 R6 R7: sweep every function, destination and source A
    crM = 32'h3c5a96e1;
    issue(4'h0, crM, 0, 0, 0, 1'b0, 0);
    for (int op = 8; op < 16; op++) begin
      for (int d = 0; d < 32; d++) begin
        for (int a = 0; a < 32; a++) begin
          int b;
          b = (a * 7 + d) % 32;
          if (a == 5) b = a;
          if (a == 9) b = d;
          issue(4'(op), 0, a, b, d, 1'b0, 0);
          crM[31-d] = refFn(op, crM[31-a], crM[31-b]);
          chk("R5 R6 R7 bit op", crOut, crM);
        end
        if (d % 8 == 0) begin
          crM = crM ^ 32'h96969696;
          issue(4'h0, crM, 0, 0, 0, 1'b0, 0);
        end
      end
    end

    // R8 R9 R11: status move over every field and pattern
    for (int f = 0; f < 8; f++) begin
      for (int p = 0; p < 8; p++) begin
        xerM = {3'(p), 29'h0a5a5a5 + 29'(f)};
        issue(4'h0, 32'hffffffff, 0, 0, 0, 1'b1, xerM);
        chk("R11 xer write", xerOut, xerM);
        crM = 32'hffffffff;
        issue(4'h2, 0, 0, 0, f + 24, 1'b0, 0);
        crM[31-4*f -: 4] = {3'(p), 1'b0};
        chk("R8 status move", crOut, crM);
        chk("R9 status cleared", xerOut, {3'b000, xerM[28:0]});
      end
    end
    issue(4'h0, 0, 0, 0, 0, 1'b1, 32'ha0000000);
    issue(4'h2, 0, 0, 0, 0, 1'b0, 0);
    chk("R9 status only clears to zero", xerOut, 32'h0);
    chk("R8 field 0", crOut, 32'ha0000000);

    // R9 collision: write wins in XER, CR takes old status
    issue(4'h0, 0, 0, 0, 0, 1'b1, 32'h40000000);
    issue(4'h2, 0, 0, 0, 1, 1'b1, 32'he0000003);
    chk("R9 collision xer", xerOut, 32'he0000003);
    chk("R9 collision cr", crOut, 32'h04000000);

    // R10: unused opcodes and idle strobe
    issue(4'h0, 32'h13579bdf, 0, 0, 0, 1'b0, 0);
    for (int op = 3; op < 8; op++) begin
      issue(4'(op), 32'hffffffff, 1, 2, 3, 1'b0, 0);
      chk("R10 unused opcode", crOut, 32'h13579bdf);
    end
    @(negedge clk);
    opCode = 4'h0; opData = 32'h0; selD = 5'd0;
    @(negedge clk); @(negedge clk);
    chk("R10 no strobe", crOut, 32'h13579bdf);

    // R1: reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 cr reset again", crOut, 32'h0);
    chk("R1 xer reset again", xerOut, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule